// File: doc/BRIEF.md
# Packed Decimal Byte Adder with Adjust

The block adds two packed binary-coded-decimal operands and a carry-in. Each operand is a byte of two decimal digits. One combinational pass produces the plain binary sum, the binary carry and the half-carry. The half-carry is the carry that leaves the low nibble. A decimal-adjust chain then turns the binary sum into a legal two-digit decimal result with its own decimal carry-out. Everything is captured in one register stage and appears one clock after the input strobe.

The adjust works one digit at a time. A digit is corrected by adding six when its nibble carried in the binary add, when it reads above nine, or when the correction below it pushed it past fifteen. The whole-word correction is therefore 0x00, 0x06, 0x60 or 0x66. The binary carry travels on its own wire, so the low-digit correction never overwrites it. The digit count is a parameter. Its default of two gives the byte-wide adder. Operands are assumed to hold legal decimal digits; the block neither checks nor handles subtraction.

Top module: `bcd_add_adjust`

## Requirements
- R1: One cycle after a strobe, `raw_sum_o` holds the low 8 bits of a + b + carry_i taken as binary numbers, and `bin_carry_o` holds bit 8 of that sum.
- R2: `half_carry_o` is 1 exactly when the low nibbles of a and b plus carry_i reach 16 or more (bit 4 of a XOR b XOR the binary sum).
- R3: Six is added to the low digit when the half-carry is set or the low nibble of the binary sum is above 9.
- R4: 0x60 is added when the binary carry is set or the sum after the low-digit correction exceeds 0x9F, counting a carry that this correction pushes out of bit 7. The total correction is 0x00, 0x06, 0x60 or 0x66.
- R5: `bcd_sum_o` holds the decimal sum a + b + carry_i modulo 100. Bits 7:4 hold the tens digit and bits 3:0 the units digit. Every output digit is 0 to 9.
- R6: `dec_carry_o` is 1 when the decimal sum is 100 or more. It is also 1 whenever the binary add carried or the 0x60 correction applied.
- R7: `out_valid_o` is 1 in the cycle after a cycle with `in_valid` high and 0 after a cycle with it low.
- R8: While `in_valid` is low, all result outputs keep their values whatever a, b and carry_i do.
- R9: A synchronous active-high `rst` clears every output to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe, one cycle per addition |
| a_i | input | 8 | First packed decimal operand |
| b_i | input | 8 | Second packed decimal operand |
| carry_i | input | 1 | Carry-in added at bit 0 |
| raw_sum_o | output | 8 | Binary sum, low 8 bits |
| bin_carry_o | output | 1 | Carry out of the binary add |
| half_carry_o | output | 1 | Carry out of the low nibble |
| bcd_sum_o | output | 8 | Adjusted two-digit decimal result |
| dec_carry_o | output | 1 | Decimal carry-out |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |

## Verification
The bench builds the block with its default of two digits. At that width the full legal input space is 100 by 100 operands times two carry-ins, so every combination is walked and compared against a digit-by-digit decimal reference and an independent binary reference. The two-digit width also makes each rare correction reachable by a directed vector. These cover a sum of 0xFA that overflows the byte only after the low-digit fix, a sum of 0x9F that needs both fixes, and the 99 + 99 + 1 maximum.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  localparam logic [3:0] DIGIT_FIX = 4'd6;
  localparam logic [3:0] DIGIT_MAX = 4'd9;

  // True when a nibble is not a legal decimal digit
  function automatic logic nib_over9(input logic [3:0] nib);
    return nib > DIGIT_MAX;
  endfunction

  // Nibble plus incoming correction carry, five bits wide
  function automatic logic [4:0] nib_bump(input logic [3:0] nib, input logic cy);
    return {1'b0, nib} + {4'd0, cy};
  endfunction

  // Adds the six-correction when fix is set, five bits wide
  function automatic logic [4:0] nib_fix(input logic [3:0] nib, input logic fix);
    return {1'b0, nib} + (fix ? {1'b0, DIGIT_FIX} : 5'd0);
  endfunction

endpackage

// File: rtl/bcd_bin_adder.sv
module bcd_bin_adder #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              cin,
  output logic [W-1:0]      sum,
  output logic              carry,
  output logic [DIGITS-1:0] nib_cy
);
  logic [W:0] full;
  logic [W:0] carries;

  assign full    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign carries = {1'b0, a} ^ {1'b0, b} ^ full;
  assign sum     = full[W-1:0];
  assign carry   = full[W];

  // Carry out of each nibble is the carry into the next nibble boundary
  for (genvar k = 0; k < DIGITS; k++) begin : g_nib
    assign nib_cy[k] = carries[4*k+4];
  end
endmodule

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
  import bcd_pkg::*;
(
  input  logic [3:0] nib_in,
  input  logic       raw_cy,
  input  logic       cy_in,
  output logic [3:0] nib_out,
  output logic       fix,
  output logic       cy_out
);
  logic [4:0] bumped;
  logic       wrapped;
  logic [4:0] fixed;

  // Correction carry from the digit below may wrap a nibble of 0xF
  assign bumped  = nib_bump(nib_in, cy_in);
  assign wrapped = bumped[4];
  assign fix     = raw_cy | wrapped | nib_over9(bumped[3:0]);
  assign fixed   = nib_fix(bumped[3:0], fix);
  assign nib_out = fixed[3:0];
  assign cy_out  = fixed[4] | wrapped;
endmodule

// File: rtl/bcd_add_adjust.sv
module bcd_add_adjust #(
  parameter int DIGITS = 2,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  output logic [W-1:0] raw_sum_o,
  output logic         bin_carry_o,
  output logic         half_carry_o,
  output logic [W-1:0] bcd_sum_o,
  output logic         dec_carry_o,
  output logic         out_valid_o
);
  // Binary stage
  logic [W-1:0]      raw_sum;
  logic              bin_carry;
  logic [DIGITS-1:0] nib_cy;
  logic              half_carry;

  bcd_bin_adder #(.DIGITS(DIGITS)) u_add (
    .a(a_i), .b(b_i), .cin(carry_i),
    .sum(raw_sum), .carry(bin_carry), .nib_cy(nib_cy)
  );
  assign half_carry = nib_cy[0];

  // Decimal adjust chain, low digit first
  logic [DIGITS:0]   fix_cy;
  logic [DIGITS-1:0] fix;
  logic [W-1:0]      bcd_sum;
  logic              dec_carry;

  assign fix_cy[0] = 1'b0;
  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    bcd_digit_fix u_fix (
      .nib_in (raw_sum[4*k +: 4]),
      .raw_cy (nib_cy[k]),
      .cy_in  (fix_cy[k]),
      .nib_out(bcd_sum[4*k +: 4]),
      .fix    (fix[k]),
      .cy_out (fix_cy[k+1])
    );
  end
  assign dec_carry = bin_carry | fix[DIGITS-1] | fix_cy[DIGITS];

  // Output register
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_sum_o    <= '0;
      bin_carry_o  <= 1'b0;
      half_carry_o <= 1'b0;
      bcd_sum_o    <= '0;
      dec_carry_o  <= 1'b0;
      out_valid_o  <= 1'b0;
    end else begin
      out_valid_o <= in_valid;
      if (in_valid) begin
        raw_sum_o    <= raw_sum;
        bin_carry_o  <= bin_carry;
        half_carry_o <= half_carry;
        bcd_sum_o    <= bcd_sum;
        dec_carry_o  <= dec_carry;
      end
    end
  end

  function automatic logic all_legal(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) ok &= (v[4*k +: 4] <= 4'd9);
    return ok;
  endfunction

  AST_RAW_SUM: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ({bin_carry_o, raw_sum_o} ==
      ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{W{1'b0}}, $past(carry_i)}))); // R1
  AST_HALF_FIX: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_carry) |-> fix[0]); // R3
  AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> all_legal(bcd_sum_o)); // R5
  AST_BIN_CARRY_KEPT: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && bin_carry_o) |-> dec_carry_o); // R6
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid_o); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid_o); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(bcd_sum_o) && $stable(raw_sum_o) && $stable(dec_carry_o))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid_o && bcd_sum_o == '0 && raw_sum_o == '0 && !dec_carry_o)); // R9
endmodule

// File: tb/bcd_add_adjust_tb_top.sv
module bcd_add_adjust_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic [7:0] raw_sum, bcd_sum;
  logic       bin_carry, half_carry, dec_carry, out_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bcd_add_adjust #(.DIGITS(2)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_i(a), .b_i(b), .carry_i(cin),
    .raw_sum_o(raw_sum), .bin_carry_o(bin_carry), .half_carry_o(half_carry),
    .bcd_sum_o(bcd_sum), .dec_carry_o(dec_carry), .out_valid_o(out_valid)
  );

  // a, b, cin, raw, bin carry, half carry, bcd, dec carry
  localparam logic [35:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h15, 8'h27, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h42, 1'b0},
    {8'h08, 8'h08, 1'b0, 8'h10, 1'b0, 1'b1, 8'h16, 1'b0},
    {8'h50, 8'h60, 1'b0, 8'hB0, 1'b0, 1'b0, 8'h10, 1'b1},
    {8'h90, 8'h90, 1'b0, 8'h20, 1'b1, 1'b0, 8'h80, 1'b1},
    {8'h99, 8'h99, 1'b1, 8'h33, 1'b1, 1'b1, 8'h99, 1'b1},
    {8'h99, 8'h61, 1'b0, 8'hFA, 1'b0, 1'b0, 8'h60, 1'b1},
    {8'h99, 8'h00, 1'b1, 8'h9A, 1'b0, 1'b0, 8'h00, 1'b1},
    {8'h45, 8'h54, 1'b0, 8'h99, 1'b0, 1'b0, 8'h99, 1'b0},
    {8'h09, 8'h09, 1'b1, 8'h13, 1'b0, 1'b1, 8'h19, 1'b0},
    {8'h58, 8'h47, 1'b0, 8'h9F, 1'b0, 1'b0, 8'h05, 1'b1},
    {8'h00, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge, sample at the next falling edge
  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic c);
    a = x; b = y; cin = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", int'(out_valid), 0);
    check("R9 reset bcd", int'(bcd_sum), 0);
    check("R9 reset raw", int'(raw_sum), 0);
    rst = 1'b0;
    @(negedge clk);

    // Table of directed vectors
    for (int i = 0; i < 12; i++) begin
      logic [35:0] v;
      v = VEC[i];
      apply(v[35:28], v[27:20], v[19]);
      check("R7 valid", int'(out_valid), 1);
      check("R1 raw sum", int'(raw_sum), int'(v[18:11]));
      check("R1 bin carry", int'(bin_carry), int'(v[10]));
      check("R2 half carry", int'(half_carry), int'(v[9]));
      check("R3 R4 R5 bcd", int'(bcd_sum), int'(v[8:1]));
      check("R6 dec carry", int'(dec_carry), int'(v[0]));
    end

    // R8: hold while idle, R7: valid drops
    apply(8'h37, 8'h48, 1'b0); // 85
    a = 8'h99; b = 8'h99; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 idle valid", int'(out_valid), 0);
    check("R8 hold bcd", int'(bcd_sum), 8'h85);
    check("R8 hold raw", int'(raw_sum), 8'h7F);
    check("R8 hold carry", int'(dec_carry), 0);

    // R9: reset mid-run
    apply(8'h99, 8'h99, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 clear bcd", int'(bcd_sum), 0);
    check("R9 clear carry", int'(dec_carry), 0);
    check("R9 clear bin carry", int'(bin_carry), 0);
    check("R9 clear valid", int'(out_valid), 0);

    // Exhaustive legal space against decimal and binary references
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        for (int c = 0; c < 2; c++) begin
          int d0, d1, k0, k1, bsum;
          logic [7:0] ax, by;
          ax = to_bcd(x); by = to_bcd(y);
          d0 = (x % 10) + (y % 10) + c;
          k0 = (d0 > 9) ? 1 : 0;
          if (k0 == 1) d0 -= 10;
          d1 = (x / 10) + (y / 10) + k0;
          k1 = (d1 > 9) ? 1 : 0;
          if (k1 == 1) d1 -= 10;
          bsum = int'(ax) + int'(by) + c;
          apply(ax, by, 1'(c));
          check("R5 bcd sum", int'(bcd_sum), (d1 << 4) | d0);
          check("R6 dec carry", int'(dec_carry), k1);
          check("R1 raw", int'({bin_carry, raw_sum}), bsum);
          check("R2 half carry", int'(half_carry),
                (int'(ax[3:0]) + int'(by[3:0]) + c > 15) ? 1 : 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule